// File: doc/BRIEF.md
# x86-16 Instruction Length Decoder

This block sits at the front of a small 16-bit x86 pipeline. It takes instruction bytes one at a time over a valid/ready byte port and works out from the opcode and the addressing byte how many bytes the current instruction spans. It then gathers those bytes into a single decoded record. Each record carries the opcode, the three addressing-byte fields, a 16-bit displacement, a 16-bit immediate already widened to its final value, the total byte count, and a flag telling whether the rm operand names a register or memory.

Only a small opcode subset is recognised: register/memory ADD (0x00 to 0x03), the immediate group (0x80, 0x81, 0x83), the increment group (0xFE, 0xFF) and the one-byte register increment (0x40 to 0x47). Any other opcode byte yields a one-byte record with an error flag, so that the decoder stays aligned with the stream. The record is held on a valid/ready output port, and no further byte is taken until the record has been accepted.

Top module: `ilen_decoder`

## Requirements
- R1: `rst` is synchronous and active high. In the cycle after it is sampled high, `out_valid` is 0 and `in_ready` is 1, and the next byte taken is treated as an opcode, even if an instruction was partly gathered.
- R2: Opcodes 0x40 to 0x47 give a record of length 1 with mod=11, reg=000, rm equal to the opcode's low three bits, rm_is_reg=1, displacement 0, immediate 0 and no error.
- R3: The byte after an opcode of 0x00-0x03, 0x80, 0x81, 0x83, 0xFE or 0xFF is the addressing byte, split as mod=bits 7:6, reg=bits 5:3, rm=bits 2:0. When mod=11, no displacement follows, rm_is_reg=1 and the displacement reads 0.
- R4: When mod=01, one displacement byte follows and is reported sign-extended to 16 bits (bit 7 copied into bits 15:8). rm_is_reg=0.
- R5: When mod=10, two displacement bytes follow, low byte first.
- R6: When mod=00 and rm=110, two displacement bytes follow, low byte first (a direct address). For any other rm with mod=00, no displacement follows and the displacement reads 0.
- R7: After any displacement, opcode 0x80 takes one immediate byte that is zero-extended. 0x81 takes two bytes, low byte first. 0x83 takes one byte that is sign-extended to 16 bits. All other opcodes report an immediate of 0.
- R8: `out_len` equals the number of bytes consumed for the instruction (opcode, addressing byte, displacement, immediate), from 1 to 6.
- R9: Any opcode outside the subset gives a record of length 1 with `out_error`=1, the opcode byte reported, and every other field 0. The following byte is taken as a new opcode.
- R10: While `out_valid` is 1, `in_ready` is 0. Every record field holds steady until a rising clock edge with `out_ready` high, after which `out_valid` drops.
- R11: A byte is consumed only on a rising edge with `in_valid` and `in_ready` both high. Idle cycles between the bytes of an instruction do not change its record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte present |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder will take a byte this cycle |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer accepts the record |
| out_opcode | output | 8 | Opcode byte |
| out_mod | output | 2 | Addressing mode field |
| out_reg | output | 3 | Register / sub-operation field |
| out_rm | output | 3 | Register or memory operand field |
| out_disp | output | 16 | Displacement, widened to 16 bits |
| out_imm | output | 16 | Immediate, widened to 16 bits |
| out_len | output | 3 | Instruction length in bytes |
| out_rm_is_reg | output | 1 | rm names a register (1) or memory (0) |
| out_error | output | 1 | Opcode outside the supported subset |

## Verification
The hardest case to reach is the six-byte instruction. It needs a 16-bit displacement followed by a 16-bit immediate, so the counter must walk both fields in turn. Next hardest is the record stall while bytes are still waiting. The stimulus sends opcode 0x81 with a mod=10 addressing byte while the output consumer withholds its ready in a repeating pattern, and inserts idle cycles between input bytes. The same scoreboard also runs a reset in the middle of an instruction and an unsupported opcode followed at once by a valid one, to show that byte alignment survives both.

// File: rtl/ilen_pkg.sv
package ilen_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int LEN_W  = 3;
  localparam int FIELD_BYTES = WORD_W / BYTE_W;

  typedef enum logic [2:0] {
    ST_OPC   = 3'd0,
    ST_MODRM = 3'd1,
    ST_DISP  = 3'd2,
    ST_IMM   = 3'd3,
    ST_HOLD  = 3'd4
  } ilen_state_e;

  typedef struct packed {
    logic       supported;
    logic       one_byte;
    logic       has_modrm;
    logic [1:0] imm_n;
    logic       imm_sext;
  } op_info_t;

  // Opcode family decode for the supported subset
  function automatic op_info_t classify(input logic [BYTE_W-1:0] op);
    op_info_t r;
    r = '0;
    if (op[7:2] == 6'b000000) begin
      r.supported = 1'b1;
      r.has_modrm = 1'b1;
    end else if (op[7:3] == 5'b01000) begin
      r.supported = 1'b1;
      r.one_byte  = 1'b1;
    end else if (op == 8'h80) begin
      r.supported = 1'b1;
      r.has_modrm = 1'b1;
      r.imm_n     = 2'd1;
    end else if (op == 8'h81) begin
      r.supported = 1'b1;
      r.has_modrm = 1'b1;
      r.imm_n     = 2'd2;
    end else if (op == 8'h83) begin
      r.supported = 1'b1;
      r.has_modrm = 1'b1;
      r.imm_n     = 2'd1;
      r.imm_sext  = 1'b1;
    end else if (op[7:1] == 7'b1111111) begin
      r.supported = 1'b1;
      r.has_modrm = 1'b1;
    end
    return r;
  endfunction

  // Number of displacement bytes implied by the addressing byte
  function automatic logic [1:0] disp_count(input logic [1:0] md, input logic [2:0] rm);
    case (md)
      2'b01:   return 2'd1;
      2'b10:   return 2'd2;
      2'b00:   return (rm == 3'b110) ? 2'd2 : 2'd0;
      default: return 2'd0;
    endcase
  endfunction

  // Widen a gathered field of n bytes to a full word
  function automatic logic [WORD_W-1:0] widen(input logic [WORD_W-1:0] raw,
                                              input logic [1:0] n,
                                              input logic sx);
    case (n)
      2'd2:    return raw;
      2'd1:    return {(sx ? {BYTE_W{raw[BYTE_W-1]}} : {BYTE_W{1'b0}}), raw[BYTE_W-1:0]};
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/ilen_opclass.sv
module ilen_opclass
  import ilen_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output op_info_t          info
);
  always_comb info = classify(opcode);
endmodule

// File: rtl/ilen_modrm_dec.sv
module ilen_modrm_dec
  import ilen_pkg::*;
(
  input  logic [BYTE_W-1:0] modrm,
  output logic [1:0]        md,
  output logic [2:0]        rg,
  output logic [2:0]        rm,
  output logic [1:0]        disp_n,
  output logic              rm_is_reg
);
  always_comb begin
    md        = modrm[7:6];
    rg        = modrm[5:3];
    rm        = modrm[2:0];
    disp_n    = disp_count(modrm[7:6], modrm[2:0]);
    rm_is_reg = (modrm[7:6] == 2'b11);
  end
endmodule

// File: rtl/ilen_byte_acc.sv
module ilen_byte_acc #(
  parameter int BYTE_W = 8,
  parameter int NB     = 2,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 we,
  input  logic [IDX_W-1:0]     idx,
  input  logic [BYTE_W-1:0]    din,
  output logic [NB*BYTE_W-1:0] value
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst || clr)
        lane_q <= '0;
      else if (we && idx == IDX_W'(g))
        lane_q <= din;
    end
    assign value[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/ilen_decoder.sv
module ilen_decoder
  import ilen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_opcode,
  output logic [1:0]        out_mod,
  output logic [2:0]        out_reg,
  output logic [2:0]        out_rm,
  output logic [15:0]       out_disp,
  output logic [15:0]       out_imm,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_rm_is_reg,
  output logic              out_error
);

  ilen_state_e state_q, state_d;

  logic [BYTE_W-1:0] op_q;
  logic [1:0]        mod_q;
  logic [2:0]        reg_q, rm_q;
  logic              rm_is_reg_q;
  logic [1:0]        disp_n_q, imm_n_q;
  logic              imm_sext_q;
  logic              idx_q;
  logic [LEN_W-1:0]  len_q;
  logic              err_q;

  // Named internal events
  logic byte_take;
  logic rec_done;
  logic field_last;

  op_info_t   info;
  logic [1:0] dec_mod, dec_disp_n;
  logic [2:0] dec_reg, dec_rm;
  logic       dec_is_reg;

  logic [WORD_W-1:0] disp_raw, imm_raw;
  logic              acc_clr, disp_we, imm_we;

  ilen_opclass u_opclass (
    .opcode (in_data),
    .info   (info)
  );

  ilen_modrm_dec u_modrm (
    .modrm     (in_data),
    .md        (dec_mod),
    .rg        (dec_reg),
    .rm        (dec_rm),
    .disp_n    (dec_disp_n),
    .rm_is_reg (dec_is_reg)
  );

  assign in_ready  = (state_q != ST_HOLD);
  assign out_valid = (state_q == ST_HOLD);
  assign byte_take = in_valid && in_ready;

  always_comb begin
    case (state_q)
      ST_DISP: field_last = (disp_n_q == 2'd1) || idx_q;
      ST_IMM:  field_last = (imm_n_q == 2'd1) || idx_q;
      default: field_last = 1'b0;
    endcase
  end

  assign acc_clr = byte_take && (state_q == ST_OPC);
  assign disp_we = byte_take && (state_q == ST_DISP);
  assign imm_we  = byte_take && (state_q == ST_IMM);

  ilen_byte_acc #(.BYTE_W(BYTE_W), .NB(FIELD_BYTES)) u_disp_acc (
    .clk   (clk),
    .rst   (rst),
    .clr   (acc_clr),
    .we    (disp_we),
    .idx   (idx_q),
    .din   (in_data),
    .value (disp_raw)
  );

  ilen_byte_acc #(.BYTE_W(BYTE_W), .NB(FIELD_BYTES)) u_imm_acc (
    .clk   (clk),
    .rst   (rst),
    .clr   (acc_clr),
    .we    (imm_we),
    .idx   (idx_q),
    .din   (in_data),
    .value (imm_raw)
  );

  // Next-state selection
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OPC: if (byte_take) begin
        if (!info.supported || info.one_byte) state_d = ST_HOLD;
        else                                  state_d = ST_MODRM;
      end
      ST_MODRM: if (byte_take) begin
        if (dec_disp_n != 2'd0)     state_d = ST_DISP;
        else if (imm_n_q != 2'd0)   state_d = ST_IMM;
        else                        state_d = ST_HOLD;
      end
      ST_DISP: if (byte_take && field_last) begin
        state_d = (imm_n_q != 2'd0) ? ST_IMM : ST_HOLD;
      end
      ST_IMM: if (byte_take && field_last) state_d = ST_HOLD;
      ST_HOLD: if (out_ready) state_d = ST_OPC;
      default: state_d = ST_OPC;
    endcase
  end

  assign rec_done = byte_take && (state_d == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_OPC;
      op_q        <= '0;
      mod_q       <= '0;
      reg_q       <= '0;
      rm_q        <= '0;
      rm_is_reg_q <= 1'b0;
      disp_n_q    <= '0;
      imm_n_q     <= '0;
      imm_sext_q  <= 1'b0;
      idx_q       <= 1'b0;
      len_q       <= '0;
      err_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (byte_take) begin
        case (state_q)
          ST_OPC: begin
            op_q        <= in_data;
            len_q       <= LEN_W'(1);
            err_q       <= !info.supported;
            disp_n_q    <= '0;
            imm_n_q     <= info.supported ? info.imm_n : 2'd0;
            imm_sext_q  <= info.imm_sext;
            idx_q       <= 1'b0;
            reg_q       <= '0;
            if (info.supported && info.one_byte) begin
              mod_q       <= 2'b11;
              rm_q        <= in_data[2:0];
              rm_is_reg_q <= 1'b1;
            end else begin
              mod_q       <= '0;
              rm_q        <= '0;
              rm_is_reg_q <= 1'b0;
            end
          end
          ST_MODRM: begin
            mod_q       <= dec_mod;
            reg_q       <= dec_reg;
            rm_q        <= dec_rm;
            rm_is_reg_q <= dec_is_reg;
            disp_n_q    <= dec_disp_n;
            len_q       <= len_q + LEN_W'(1);
          end
          ST_DISP, ST_IMM: begin
            len_q <= len_q + LEN_W'(1);
            idx_q <= field_last ? 1'b0 : 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign out_opcode    = op_q;
  assign out_mod       = mod_q;
  assign out_reg       = reg_q;
  assign out_rm        = rm_q;
  assign out_disp      = widen(disp_raw, disp_n_q, 1'b1);
  assign out_imm       = widen(imm_raw, imm_n_q, imm_sext_q);
  assign out_len       = len_q;
  assign out_rm_is_reg = rm_is_reg_q;
  assign out_error     = err_q;

endmodule

// File: rtl/ilen_decoder_chk.sv
module ilen_decoder_chk
  import ilen_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              byte_take,
  input logic              rec_done,
  input logic [7:0]        out_opcode,
  input logic [15:0]       out_disp,
  input logic [15:0]       out_imm,
  input logic [LEN_W-1:0]  out_len,
  input logic              out_rm_is_reg,
  input logic              out_error
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  // R2
  one_byte_len_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_error && out_opcode[7:3] == 5'b01000) |-> (out_len == 3'd1 && out_rm_is_reg));

  // R3
  reg_form_no_disp_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_rm_is_reg) |-> (out_disp == 16'h0000));

  // R8
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd6));

  // R8
  done_gives_record_chk: assert property (@(posedge clk) disable iff (rst)
    rec_done |=> out_valid);

  // R9
  error_short_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_error) |-> (out_len == 3'd1 && out_imm == 16'h0000 && out_disp == 16'h0000));

  // R10
  hold_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R10
  record_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_len) && $stable(out_disp) && $stable(out_imm) && $stable(out_opcode)));

  // R11
  no_take_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    byte_take |-> !out_valid);

endmodule

bind ilen_decoder ilen_decoder_chk u_ilen_chk (
  .clk           (clk),
  .rst           (rst),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .byte_take     (byte_take),
  .rec_done      (rec_done),
  .out_opcode    (out_opcode),
  .out_disp      (out_disp),
  .out_imm       (out_imm),
  .out_len       (out_len),
  .out_rm_is_reg (out_rm_is_reg),
  .out_error     (out_error)
);

// File: tb/test_ilen_decoder.sv
`timescale 1ns/1ps
module test_ilen_decoder;

  typedef struct packed {
    logic [7:0]  op;
    logic [1:0]  md;
    logic [2:0]  rg;
    logic [2:0]  rm;
    logic [15:0] disp;
    logic [15:0] imm;
    logic [2:0]  len;
    logic        isreg;
    logic        err;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_opcode;
  logic [1:0]  out_mod;
  logic [2:0]  out_reg, out_rm;
  logic [15:0] out_disp, out_imm;
  logic [2:0]  out_len;
  logic        out_rm_is_reg, out_error;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit monitor_on = 1'b0;
  bit finished = 1'b0;

  rec_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  ilen_decoder i_ilen_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode), .out_mod(out_mod),
    .out_reg(out_reg), .out_rm(out_rm), .out_disp(out_disp), .out_imm(out_imm),
    .out_len(out_len), .out_rm_is_reg(out_rm_is_reg), .out_error(out_error)
  );

  function automatic rec_t mk(input logic [7:0] op, input logic [1:0] md, input logic [2:0] rg,
                              input logic [2:0] rm, input logic [15:0] disp, input logic [15:0] imm,
                              input logic [2:0] len, input logic isreg, input logic err);
    rec_t r;
    r.op = op; r.md = md; r.rg = rg; r.rm = rm; r.disp = disp; r.imm = imm;
    r.len = len; r.isreg = isreg; r.err = err;
    return r;
  endfunction

  function automatic rec_t cur_rec();
    return mk(out_opcode, out_mod, out_reg, out_rm, out_disp, out_imm, out_len, out_rm_is_reg, out_error);
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive n bytes (first byte in bits 7:0), with gap idle cycles after each
  task automatic feed(input logic [47:0] bytes, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = bytes[i*8 +: 8];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic send(input logic [47:0] bytes, input int n, input rec_t exp, input int gap, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    feed(bytes, n, gap);
  endtask

  // Monitor / scoreboard
  bit   hold_pending = 1'b0;
  rec_t held;
  always @(negedge clk) begin
    cyc++;
    if (monitor_on && !rst) begin
      if (hold_pending) begin
        check(out_valid && cur_rec() == held, "R10", "record changed while stalled",
              64'(cur_rec()), 64'(held));
        hold_pending = 1'b0;
      end
      if (out_valid)
        check(!in_ready, "R10", "in_ready during held record", 64'(in_ready), 64'd0);
      out_ready = ((cyc % 3) != 1);
      if (out_valid) begin
        if (out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected record", 64'(cur_rec()), 64'd0);
          end else begin
            rec_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(cur_rec() == e, t, "record mismatch", 64'(cur_rec()), 64'(e));
          end
        end else begin
          held = cur_rec();
          hold_pending = 1'b1;
        end
      end
    end
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle state while and after reset
    check(!out_valid && in_ready, "R1", "state during reset", {out_valid, in_ready}, 64'b01);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R1", "state after reset", {out_valid, in_ready}, 64'b01);
    monitor_on = 1'b1;

    send(48'h40, 1, mk(8'h40, 2'b11, 3'd0, 3'd0, 16'h0, 16'h0, 3'd1, 1'b1, 1'b0), 0, "R2");
    send(48'h47, 1, mk(8'h47, 2'b11, 3'd0, 3'd7, 16'h0, 16'h0, 3'd1, 1'b1, 1'b0), 0, "R2");
    send(48'h55AAC081, 4, mk(8'h81, 2'b11, 3'd0, 3'd0, 16'h0, 16'h55AA, 3'd4, 1'b1, 1'b0), 0, "R7");
    send(48'h55AA0603, 4, mk(8'h03, 2'b00, 3'd0, 3'd6, 16'h55AA, 16'h0, 3'd4, 1'b0, 1'b0), 1, "R6");
    send(48'hC0FE, 2, mk(8'hFE, 2'b11, 3'd0, 3'd0, 16'h0, 16'h0, 3'd2, 1'b1, 1'b0), 0, "R3");
    send(48'hC0FF, 2, mk(8'hFF, 2'b11, 3'd0, 3'd0, 16'h0, 16'h0, 3'd2, 1'b1, 1'b0), 2, "R3");
    send(48'hD800, 2, mk(8'h00, 2'b11, 3'd3, 3'd0, 16'h0, 16'h0, 3'd2, 1'b1, 1'b0), 0, "R3");
    send(48'hF04701, 3, mk(8'h01, 2'b01, 3'd0, 3'd7, 16'hFFF0, 16'h0, 3'd3, 1'b0, 1'b0), 0, "R4");
    send(48'h104502, 3, mk(8'h02, 2'b01, 3'd0, 3'd5, 16'h0010, 16'h0, 3'd3, 1'b0, 1'b0), 1, "R4");
    send(48'h567812348681, 6, mk(8'h81, 2'b10, 3'd0, 3'd6, 16'h1234, 16'h5678, 3'd6, 1'b0, 1'b0), 0, "R5");
    send(48'h567812348681, 6, mk(8'h81, 2'b10, 3'd0, 3'd6, 16'h1234, 16'h5678, 3'd6, 1'b0, 1'b0), 3, "R11");
    send(48'h80C383, 3, mk(8'h83, 2'b11, 3'd0, 3'd3, 16'h0, 16'hFF80, 3'd3, 1'b1, 1'b0), 0, "R7");
    send(48'h7FC383, 3, mk(8'h83, 2'b11, 3'd0, 3'd3, 16'h0, 16'h007F, 3'd3, 1'b1, 1'b0), 0, "R7");
    send(48'h80C180, 3, mk(8'h80, 2'b11, 3'd0, 3'd1, 16'h0, 16'h0080, 3'd3, 1'b1, 1'b0), 0, "R7");
    send(48'h05FE4683, 4, mk(8'h83, 2'b01, 3'd0, 3'd6, 16'hFFFE, 16'h0005, 3'd4, 1'b0, 1'b0), 0, "R8");
    send(48'h0700, 2, mk(8'h00, 2'b00, 3'd0, 3'd7, 16'h0, 16'h0, 3'd2, 1'b0, 1'b0), 0, "R6");
    send(48'h0F, 1, mk(8'h0F, 2'b00, 3'd0, 3'd0, 16'h0, 16'h0, 3'd1, 1'b0, 1'b1), 0, "R9");
    send(48'h41, 1, mk(8'h41, 2'b11, 3'd0, 3'd1, 16'h0, 16'h0, 3'd1, 1'b1, 1'b0), 0, "R9");
    send(48'h82, 1, mk(8'h82, 2'b00, 3'd0, 3'd0, 16'h0, 16'h0, 3'd1, 1'b0, 1'b1), 0, "R9");

    // R1: reset in the middle of an instruction
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
    feed(48'hC081, 2, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R1", "state after mid-instruction reset", {out_valid, in_ready}, 64'b01);
    send(48'h43, 1, mk(8'h43, 2'b11, 3'd0, 3'd3, 16'h0, 16'h0, 3'd1, 1'b1, 1'b0), 0, "R1");

    while (exp_q.size() != 0 || out_valid) @(negedge clk);
    repeat (4) @(negedge clk);
    check(!out_valid, "R10", "stray record at end", 64'(out_valid), 64'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule